// File: doc/BRIEF.md
# Line-Locked Horizontal Timing Generator

This block keeps a horizontal pixel counter in step with an active-low composite sync input that has already been sliced and brought into the pixel clock domain. A noise gate compares each sync falling edge against a programmable count window. Edges outside the window are dropped, which removes the equalization and serration pulses that occur at half-line spacing during the vertical interval. An accepted edge restarts the line count at zero after a fixed pipeline of three clocks.

The counter has two reset modes. In tracking mode an accepted edge zeroes it, and it wraps on its own at the programmed length when no edge arrives. In fixed-length mode it always completes the programmed line and then waits at the last count for the next edge. Three windowed outputs (clamp, zero and horizontal sync) go active and inactive at programmed counts, and each has its own polarity.

All settings are loaded through an 8-bit write port. Each 12-bit value is written as a low byte and a high byte into a staging copy, which is moved into the working copy only on the clock where the counter returns to zero.

Top module: `line_lock_htimer`

## Requirements
- R1: After reset hcount_o is 0, all three outputs are high (every polarity bit is 0), the line length is DEF_LEN (255 by default), the gate window is 0..4095, and every output window has start equal to stop.
- R2: The line-length value holds the pixel count per line minus one. In tracking mode, with no accepted edge, hcount_o counts 0 up to that value and the next clock returns it to 0.
- R3: Write map (cfg_we high, one write per clock). Address 0 is the mode: bit0 selects fixed-length mode, and bits 1, 2 and 3 make clamp, zero and hsync active-high when set. Addresses 1 to 18 are low/high byte pairs (odd address is the low byte, even address is bits 11:8 taken from data bits 3:0) for these values in order: line length, gate start, gate stop, clamp start, clamp stop, zero start, zero stop, hsync start, hsync stop. Other addresses are ignored.
- R4: A written value (other than the mode) takes effect at the clock edge where hcount_o next becomes 0. Until then the previous value stays in force. The mode takes effect at the next clock.
- R5: If csync_n is first sampled low at clock edge n after a high sample, and the edge is accepted, hcount_o reads 0 after edge n+3.
- R6: In tracking mode an edge is accepted only if the count held after edge n+2 lies within the gate window, inclusive of both ends. A rejected edge leaves the count sequence unchanged.
- R7: In fixed-length mode hcount_o counts up to the line length and holds there. The first edge whose count at edge n+2 equals the line length zeroes it. Edges that arrive earlier are ignored.
- R8: Each output becomes active one clock after hcount_o equals its start value, and becomes inactive one clock after hcount_o equals its stop value. A window with start greater than stop spans the line wrap.
- R9: An output whose start equals its stop value never becomes active.
- R10: An output's polarity bit selects its active level. A change to that bit shows on the output one clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Sliced composite sync, active low, pixel-clock synchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW (5) | Register address |
| cfg_wdata | input | 8 | Register write data |
| hcount_o | output | W (12) | Current horizontal pixel count |
| clamp_o | output | 1 | Clamp window output |
| zero_o | output | 1 | Zero window output |
| hsync_o | output | 1 | Horizontal sync window output |

## Verification
The hardest state to reach is the one where a staged value is pending while the counter runs under the old one. This applies most of all to a line-length change that arrives mid-line, or while the counter holds at the end of a fixed-length line. The stimulus writes values during live lines and compares every cycle against a behavioural model. Gate rejection is also hard to provoke. It is driven with a sync source that carries half-line pulses, and with a source whose period is shorter than the programmed line, so that some edges land inside the window and others outside it.

// File: rtl/hlt_pkg.sv
package hlt_pkg;
    localparam int N_WIN      = 3;
    localparam int N_VAL      = 3 + 2 * N_WIN;
    localparam int MODE_W     = 1 + N_WIN;
    localparam int MODE_FIXED = 0;
    localparam int IDX_LEN    = 0;
    localparam int IDX_GSTART = 1;
    localparam int IDX_GSTOP  = 2;

    function automatic int start_idx(input int w);
        return 3 + 2 * w;
    endfunction

    function automatic int stop_idx(input int w);
        return 4 + 2 * w;
    endfunction
endpackage

// File: rtl/hlt_sync_edge.sv
// Detects a falling edge of the sync input and delays it by DLY clocks.
// DLY must be at least 2.
module hlt_sync_edge #(
    parameter int DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n,
    output logic edge_o
);
    typedef struct packed {
        logic           s1;
        logic           s2;
        logic [DLY-1:0] pipe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = csync_n;
        st_d.s2   = st_q.s1;
        st_d.pipe = {st_q.pipe[DLY-2:0], st_q.s2 & ~st_q.s1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1   <= 1'b1;
            st_q.s2   <= 1'b1;
            st_q.pipe <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_o = st_q.pipe[DLY-1];

    // R5: one sync fall yields exactly one delayed pulse
    p_single_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/hlt_regs.sv
// Staging and working copies of the settings; working copy loads on load_i.
module hlt_regs #(
    parameter int W       = 12,
    parameter int AW      = 5,
    parameter int NV      = 9,
    parameter int MW      = 4,
    parameter int DEF_LEN = 255
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [7:0]           data_i,
    input  logic                 load_i,
    output logic [MW-1:0]        mode_o,
    output logic [NV-1:0][W-1:0] live_o
);
    import hlt_pkg::*;

    localparam logic [AW-1:0] LAST_ADDR = AW'(2 * NV);
    localparam int            HB        = W - 8;

    typedef struct packed {
        logic [MW-1:0]        mode;
        logic [NV-1:0][W-1:0] stage;
        logic [NV-1:0][W-1:0] live;
    } rf_t;

    rf_t           rf_d, rf_q;
    logic [AW-1:0] a1;

    function automatic rf_t rst_val();
        rf_t r;
        r                  = '0;
        r.stage[IDX_LEN]   = W'(DEF_LEN);
        r.stage[IDX_GSTOP] = '1;
        r.live             = r.stage;
        return r;
    endfunction

    always_comb begin
        rf_d = rf_q;
        a1   = addr_i - AW'(1);
        if (load_i) rf_d.live = rf_q.stage;
        if (we_i) begin
            if (addr_i == '0) begin
                rf_d.mode = data_i[MW-1:0];
            end else if (addr_i <= LAST_ADDR) begin
                for (int i = 0; i < NV; i++) begin
                    if (int'(a1[AW-1:1]) == i) begin
                        if (a1[0]) rf_d.stage[i][W-1:8] = data_i[HB-1:0];
                        else       rf_d.stage[i][7:0]   = data_i;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= rst_val();
        else        rf_q <= rf_d;
    end

    assign mode_o = rf_q.mode;
    assign live_o = rf_q.live;

    // R4: working values move only when the counter restarts
    p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(live_o));
endmodule

// File: rtl/hlt_counter.sv
// Horizontal counter with gated restart, tracking and fixed-length modes.
module hlt_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         edge_i,
    input  logic         fixed_i,
    input  logic [W-1:0] len_i,
    input  logic [W-1:0] gstart_i,
    input  logic [W-1:0] gstop_i,
    output logic [W-1:0] count_o,
    output logic         load_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cs_t;

    cs_t  cs_d, cs_q;
    logic in_gate, at_end;

    always_comb begin
        cs_d    = cs_q;
        in_gate = (cs_q.cnt >= gstart_i) && (cs_q.cnt <= gstop_i);
        at_end  = (cs_q.cnt == len_i);
        if (fixed_i) begin
            if (at_end) cs_d.cnt = edge_i ? '0 : cs_q.cnt;
            else        cs_d.cnt = cs_q.cnt + W'(1);
        end else begin
            if ((edge_i && in_gate) || at_end) cs_d.cnt = '0;
            else                               cs_d.cnt = cs_q.cnt + W'(1);
        end
        load_o = (cs_d.cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign count_o = cs_q.cnt;

    p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= len_i);

    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fixed_i && edge_i && count_o >= gstart_i && count_o <= gstop_i)
        |=> count_o == '0);

    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fixed_i && edge_i && (count_o < gstart_i || count_o > gstop_i) && count_o != len_i)
        |=> count_o == $past(count_o) + W'(1));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_i && count_o == len_i && !edge_i) |=> count_o == $past(count_o));
endmodule

// File: rtl/hlt_window.sv
// One start/stop compare output with selectable polarity.
module hlt_window #(
    parameter int   W         = 12,
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count_i,
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] stop_i,
    input  logic         inv_i,
    output logic         out_o
);
    typedef struct packed {
        logic act;
        logic out;
    } ws_t;

    ws_t ws_d, ws_q;

    always_comb begin
        ws_d = ws_q;
        if (count_i == stop_i)       ws_d.act = 1'b0;
        else if (count_i == start_i) ws_d.act = 1'b1;
        ws_d.out = ws_d.act ^ inv_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q.act <= 1'b0;
            ws_q.out <= RST_LEVEL;
        end else begin
            ws_q <= ws_d;
        end
    end

    assign out_o = ws_q.out;

    p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == start_i && start_i != stop_i) |=> out_o == !$past(inv_i));

    p_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_i == start_i && start_i == stop_i) |=> out_o == $past(inv_i));
endmodule

// File: rtl/line_lock_htimer.sv
module line_lock_htimer #(
    parameter int W        = 12,
    parameter int AW       = 5,
    parameter int DEF_LEN  = 255,
    parameter int EDGE_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csync_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [7:0]    cfg_wdata,
    output logic [W-1:0]  hcount_o,
    output logic          clamp_o,
    output logic          zero_o,
    output logic          hsync_o
);
    import hlt_pkg::*;

    logic                    edge_dly;
    logic                    load;
    logic [MODE_W-1:0]       mode;
    logic [N_VAL-1:0][W-1:0] live;
    logic [W-1:0]            count;
    logic [N_WIN-1:0]        win_out;

    hlt_sync_edge #(.DLY(EDGE_DLY)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .csync_n (csync_n),
        .edge_o  (edge_dly)
    );

    hlt_regs #(.W(W), .AW(AW), .NV(N_VAL), .MW(MODE_W), .DEF_LEN(DEF_LEN)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we),
        .addr_i (cfg_addr),
        .data_i (cfg_wdata),
        .load_i (load),
        .mode_o (mode),
        .live_o (live)
    );

    hlt_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (edge_dly),
        .fixed_i  (mode[MODE_FIXED]),
        .len_i    (live[IDX_LEN]),
        .gstart_i (live[IDX_GSTART]),
        .gstop_i  (live[IDX_GSTOP]),
        .count_o  (count),
        .load_o   (load)
    );

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        hlt_window #(.W(W), .RST_LEVEL(1'b1)) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .count_i (count),
            .start_i (live[start_idx(w)]),
            .stop_i  (live[stop_idx(w)]),
            .inv_i   (~mode[1 + w]),
            .out_o   (win_out[w])
        );
    end

    assign hcount_o = count;
    assign clamp_o  = win_out[0];
    assign zero_o   = win_out[1];
    assign hsync_o  = win_out[2];
endmodule

// File: tb/line_lock_htimer_tb.sv
module line_lock_htimer_tb;
    localparam int DEF_LEN = 255;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csync_n = 1'b1;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [11:0] hcount_o;
    logic       clamp_o, zero_o, hsync_o;

    always #10 clk = ~clk;

    line_lock_htimer #(.DEF_LEN(DEF_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .csync_n(csync_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hcount_o(hcount_o), .clamp_o(clamp_o), .zero_o(zero_o), .hsync_o(hsync_o)
    );

    int    vectors = 0;
    int    miscmp = 0;
    int    cyc = 0;
    bit    run_cmp = 0;
    string cur_tag = "R1";

    task automatic chk(string tag, int act, int exp, string what);
        vectors++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_cnt, m_nx, m_len, m_idx;
    bit  m_act[3];
    bit  m_out[3];
    int  m_stage[9];
    int  m_live[9];
    bit  [3:0] m_mode;
    bit  m_prev, m_fall, m_use, m_in;
    bit  m_fq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_mode = '0;
            m_prev = 1'b1;
            m_fq = '{1'b0, 1'b0, 1'b0};
            for (int i = 0; i < 9; i++) m_stage[i] = 0;
            m_stage[0] = DEF_LEN;
            m_stage[2] = 4095;
            for (int i = 0; i < 9; i++) m_live[i] = m_stage[i];
            for (int w = 0; w < 3; w++) begin m_act[w] = 0; m_out[w] = 1; end
        end else begin
            m_fall = m_prev && !csync_n;
            m_prev = csync_n;
            m_use  = m_fq.pop_front();
            m_fq.push_back(m_fall);
            m_len = m_live[0];
            m_in  = (m_cnt >= m_live[1]) && (m_cnt <= m_live[2]);
            if (m_mode[0]) begin
                if (m_cnt == m_len) m_nx = m_use ? 0 : m_cnt;
                else                m_nx = m_cnt + 1;
            end else begin
                if ((m_use && m_in) || m_cnt == m_len) m_nx = 0;
                else                                   m_nx = m_cnt + 1;
            end
            for (int w = 0; w < 3; w++) begin
                if (m_cnt == m_live[4 + 2*w])      m_act[w] = 0;
                else if (m_cnt == m_live[3 + 2*w]) m_act[w] = 1;
                m_out[w] = m_act[w] ^ !m_mode[1 + w];
            end
            if (m_nx == 0) for (int i = 0; i < 9; i++) m_live[i] = m_stage[i];
            if (cfg_we) begin
                if (cfg_addr == 0) m_mode = cfg_wdata[3:0];
                else if (cfg_addr <= 18) begin
                    m_idx = (cfg_addr - 1) / 2;
                    if (((cfg_addr - 1) % 2) == 1)
                        m_stage[m_idx] = (m_stage[m_idx] & 255) | ((cfg_wdata & 15) << 8);
                    else
                        m_stage[m_idx] = (m_stage[m_idx] & 'hF00) | cfg_wdata;
                end
            end
            m_cnt = m_nx;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk(cur_tag, hcount_o, m_cnt, "hcount");
            chk(cur_tag, clamp_o, m_out[0], "clamp");
            chk(cur_tag, zero_o, m_out[1], "zero");
            chk(cur_tag, hsync_o, m_out[2], "hsync");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            miscmp++;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(int a, int d);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(int n);
        csync_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic gen(int period, int width, bit eq, int ncyc);
        for (int i = 0; i < ncyc; i++) begin
            int p;
            p = i % period;
            csync_n = !((p < width) || (eq && p >= period/2 && p < period/2 + width/2));
            @(negedge clk);
        end
        csync_n = 1'b1;
    endtask

    int max_cnt, run_len, best_run, act_cnt, k_zero;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", hcount_o, 0, "hcount after reset");
        chk("R1", clamp_o, 1, "clamp idle level");
        chk("R1", zero_o, 1, "zero idle level");
        chk("R1", hsync_o, 1, "hsync idle level");
        run_cmp = 1;
        cur_tag = "R1";
        idle(600);

        // R3 R4: program mid-line, values apply at next count zero
        cur_tag = "R3 R4";
        wr(1, 99);  wr(2, 0);
        wr(3, 95);  wr(4, 0);
        wr(5, 99);  wr(6, 0);
        wr(7, 10);  wr(8, 0);  wr(9, 20);  wr(10, 0);
        wr(11, 30); wr(12, 0); wr(13, 45); wr(14, 0);
        wr(15, 98); wr(16, 0); wr(17, 6);  wr(18, 0);
        wr(19, 77); wr(31, 5);
        wr(0, 'h0A);
        idle(300);

        // R6 R8: half-line pulses rejected by the gate
        cur_tag = "R6 R8";
        gen(98, 7, 1'b1, 1500);

        // R2 R6: edges too early for the gate, counter wraps at length
        cur_tag = "R2 R6";
        max_cnt = 0;
        for (int i = 0; i < 800; i++) begin
            int p;
            p = i % 60;
            csync_n = !(p < 5);
            @(negedge clk);
            if (int'(hcount_o) > max_cnt) max_cnt = int'(hcount_o);
        end
        chk("R2", max_cnt, 99, "largest count with early edges");

        // R5: three clocks from first low sample to count zero
        cur_tag = "R5";
        wr(3, 0); wr(4, 0);
        idle(250);
        while (hcount_o != 12'd50) @(negedge clk);
        csync_n = 1'b0;
        k_zero = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (k_zero == 0 && hcount_o == 12'd0) k_zero = k;
        end
        chk("R5", k_zero, 4, "negedges until zero after driving low");
        idle(200);

        // R7: fixed-length mode with a 260 length (high byte used)
        cur_tag = "R7";
        wr(1, 'h04); wr(2, 'h01);
        wr(0, 'h0B);
        best_run = 0; run_len = 0;
        for (int i = 0; i < 2400; i++) begin
            int p;
            p = i % 300;
            csync_n = !((p < 10) || (p >= 150 && p < 155));
            @(negedge clk);
            if (hcount_o == 12'd260) run_len++; else run_len = 0;
            if (run_len > best_run) best_run = run_len;
        end
        chk("R7", int'(best_run >= 2), 1, "count held at line end");

        // R9: clamp start equal to stop never activates
        cur_tag = "R9";
        wr(9, 10); wr(10, 0);
        gen(300, 10, 1'b0, 700);
        act_cnt = 0;
        for (int i = 0; i < 700; i++) begin
            int p;
            p = i % 300;
            csync_n = !(p < 10);
            @(negedge clk);
            if (clamp_o == 1'b1) act_cnt++;
        end
        chk("R9", act_cnt, 0, "clamp active cycles");

        // R10: polarity change, back to tracking mode
        cur_tag = "R10";
        wr(0, 'h04);
        @(negedge clk);
        chk("R10", clamp_o, 1, "clamp idle level active-low");
        gen(261, 8, 1'b1, 900);

        run_cmp = 0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule